// File: doc/BRIEF.md
# Interrupt Source P/Q State Controller

This block keeps a two-bit event state for each of a parameterised number of interrupt sources. Bit P (bit 1 of the state) records that an event has been passed on and not yet acknowledged. Bit Q (bit 0) records that a further event arrived while P was set. Software reaches the state through a load/store window. In it, each source owns one page, or a pair of pages, and the offset within the page selects the operation. Loads and stores change the state as a side effect. A hardware trigger port with valid/ready handshake runs the same trigger transition as a store. Whenever an event must be forwarded, the block emits a one-cycle notify pulse carrying the source number.

A source can be marked level-sensitive at build time. A level-sensitive source only ever sets P. When such a source receives an end-of-interrupt, it samples its level input and re-raises the event if the level is still high. A global bypass input makes every trigger notify without touching the state.

The bus side has no back-pressure: every access is taken in the cycle it is presented. The hardware trigger port is stalled (`trig_ready` low) in any cycle that carries a bus access, and the trigger is taken once the bus is idle. The notify output has no ready: the consumer must take every pulse.

Top module: `pq_source_ctl`

## Requirements
- R1: After reset every source holds RESET_PQ (default 2'b01: P=0, Q=1, masked). No response or notify is emitted until an access arrives.
- R2: The source number is `bus_addr >> (PAGE_BITS + TWO_PAGE)`. With TWO_PAGE=1, `bus_addr[PAGE_BITS]`=0 selects the trigger page and 1 selects the management page. The operation offset is `bus_addr[11:0]`.
- R3: A trigger (trigger-page store, single-page store at offset 0x000-0x3FF, or accepted hardware trigger) moves 00 to 10 with notify, moves 10 or 11 to 11 without notify, and leaves 01 unchanged without notify.
- R4: A management-page load at offset 0x000-0x7FF is an end-of-interrupt. It moves 10 to 00 and returns 0, and moves 11 to 10, returns 1 and notifies. It leaves 00 and 01 unchanged and returns 0.
- R5: A management-page load at 0x800-0xBFF returns the state in data bits [1:0] with no change. A load at 0xC00-0xFFF returns the old state and then sets the state to `bus_addr[9:8]`.
- R6: A management-page store at 0xC00-0xFFF sets the state to `bus_addr[9:8]`. Management-page stores at 0x800-0xBFF, and (two-page mode) at 0x000-0x3FF, have no effect.
- R7: A management-page store at 0x400-0x7FF performs the end-of-interrupt of R4 (without a response) only when `store_eoi_en` is 1. Otherwise it has no effect.
- R8: In two-page mode a load from the trigger page returns all ones and leaves the state unchanged. So does a load addressed to a source number at or above NUM_SRC.
- R9: While `pq_disable` is 1, every trigger notifies and leaves the state unchanged. An end-of-interrupt returns 0 and changes nothing.
- R10: For a source set in LSI_MAP, a trigger moves 00 to 10 with notify and otherwise changes nothing. An end-of-interrupt from 10 gives 10 with notify and returns 1 if its `lvl_in` bit is 1, else 00 and returns 0. From 11 it gives 01. From 00 and 01 it changes nothing.
- R11: `trig_ready` is 0 in any cycle with `bus_valid`=1. A held hardware trigger is taken in the first cycle without a bus access, and only then.
- R12: A load response (`rsp_valid`, `rsp_data`) and a notify pulse (`notify_valid`, `notify_src`) appear exactly one cycle after the accepting clock edge and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pq_disable | input | 1 | Bypass the state machine: triggers always notify |
| store_eoi_en | input | 1 | Allows end-of-interrupt by store |
| lvl_in | input | NUM_SRC | Level inputs of level-sensitive sources |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_load | input | 1 | 1 = load, 0 = store |
| bus_addr | input | ADDR_W | Access address |
| rsp_valid | output | 1 | Load response strobe |
| rsp_data | output | DATA_W | Load response data |
| trig_valid | input | 1 | Hardware trigger request |
| trig_ready | output | 1 | Hardware trigger accepted this cycle |
| trig_src | input | SRC_W | Hardware trigger source number |
| notify_valid | output | 1 | Notify pulse |
| notify_src | output | SRC_W | Source number carried by the notify pulse |

## Verification
Every accepted access has its results due exactly one cycle after the edge that takes it. The load response and the notify pulse both come from flops fed by the same combinational transition. The driver stamps each expected item with the cycle counter plus one when it presents the access. The monitor samples on the falling edge and compares the front item only when its stamp matches the current cycle. In any other cycle it treats a response or notify as unexpected. For a stalled hardware trigger the expected notify is stamped one cycle later, for the cycle in which the bus goes idle.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // Operation chosen by the address decoder or the trigger port
  typedef enum logic [2:0] {
    PQ_OP_NONE  = 3'd0,
    PQ_OP_TRIG  = 3'd1,
    PQ_OP_EOI   = 3'd2,
    PQ_OP_PEEK  = 3'd3,
    PQ_OP_SWAP  = 3'd4,
    PQ_OP_FORCE = 3'd5,
    PQ_OP_BADLD = 3'd6
  } pq_op_e;

  // State encoding: bit 1 = P (forwarded), bit 0 = Q (pending behind P)
  localparam logic [1:0] PQ_IDLE    = 2'b00;
  localparam logic [1:0] PQ_MASKED  = 2'b01;
  localparam logic [1:0] PQ_ACTIVE  = 2'b10;
  localparam logic [1:0] PQ_PENDING = 2'b11;

  // Offset field of a page
  localparam int OFF_W = 12;

endpackage

// File: rtl/pq_decode.sv
module pq_decode
  import pq_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int PAGE_BITS = 12,
  parameter int TWO_PAGE  = 1,
  parameter int SRC_W     = $clog2(NUM_SRC),
  parameter int ADDR_W    = PAGE_BITS + TWO_PAGE + SRC_W
) (
  input  logic              valid,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              store_eoi_en,
  output pq_op_e            op,
  output logic [SRC_W-1:0]  src,
  output logic [1:0]        set_val
);

  localparam int SRC_SHIFT = PAGE_BITS + TWO_PAGE;

  logic [OFF_W-1:0] off;
  logic             trig_page;
  logic             odd_trig_ok;
  logic             in_range;
  logic             unused_addr_bits;

  assign off     = addr[OFF_W-1:0];
  assign src     = addr[SRC_SHIFT +: SRC_W];
  assign set_val = off[9:8];
  assign in_range = ({1'b0, src} < (SRC_W+1)'(NUM_SRC));
  assign unused_addr_bits = ^addr;

  generate
    if (TWO_PAGE != 0) begin : g_two_page
      assign trig_page   = ~addr[PAGE_BITS];
      assign odd_trig_ok = 1'b0;
    end else begin : g_one_page
      assign trig_page   = 1'b0;
      assign odd_trig_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    op = PQ_OP_NONE;
    if (valid) begin
      if (!in_range) begin
        op = load ? PQ_OP_BADLD : PQ_OP_NONE;
      end else if (load) begin
        if (trig_page) begin
          op = PQ_OP_BADLD;
        end else begin
          unique case (off[11:10])
            2'b00, 2'b01: op = PQ_OP_EOI;
            2'b10:        op = PQ_OP_PEEK;
            default:      op = PQ_OP_SWAP;
          endcase
        end
      end else begin
        if (trig_page) begin
          op = PQ_OP_TRIG;
        end else begin
          unique case (off[11:10])
            2'b00:   op = odd_trig_ok ? PQ_OP_TRIG : PQ_OP_NONE;
            2'b01:   op = store_eoi_en ? PQ_OP_EOI : PQ_OP_NONE;
            2'b10:   op = PQ_OP_NONE;
            default: op = PQ_OP_FORCE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pq_engine.sv
module pq_engine
  import pq_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  pq_op_e            op,
  input  logic [1:0]        cur,
  input  logic [1:0]        set_val,
  input  logic              lsi,
  input  logic              level,
  input  logic              bypass,
  output logic [1:0]        nxt,
  output logic              wr,
  output logic              ntf,
  output logic [DATA_W-1:0] rdata
);

  logic ret;

  always_comb begin
    nxt = cur;
    ntf = 1'b0;
    ret = 1'b0;
    unique case (op)
      PQ_OP_TRIG: begin
        if (bypass) begin
          ntf = 1'b1;
        end else if (lsi) begin
          if (cur == PQ_IDLE) begin
            nxt = PQ_ACTIVE;
            ntf = 1'b1;
          end
        end else begin
          unique case (cur)
            PQ_IDLE:    begin nxt = PQ_ACTIVE; ntf = 1'b1; end
            PQ_ACTIVE,
            PQ_PENDING: nxt = PQ_PENDING;
            default:    nxt = cur;
          endcase
        end
      end
      PQ_OP_EOI: begin
        if (!bypass) begin
          if (lsi) begin
            if (cur == PQ_PENDING) begin
              nxt = PQ_MASKED;
            end else if (cur == PQ_ACTIVE) begin
              if (level) begin
                ntf = 1'b1;
                ret = 1'b1;
              end else begin
                nxt = PQ_IDLE;
              end
            end
          end else begin
            if (cur == PQ_ACTIVE) begin
              nxt = PQ_IDLE;
            end else if (cur == PQ_PENDING) begin
              nxt = PQ_ACTIVE;
              ntf = 1'b1;
              ret = 1'b1;
            end
          end
        end
      end
      PQ_OP_SWAP, PQ_OP_FORCE: nxt = set_val;
      default: nxt = cur;
    endcase
  end

  assign wr = (nxt != cur);

  always_comb begin
    rdata = '0;
    unique case (op)
      PQ_OP_BADLD:             rdata = '1;
      PQ_OP_EOI:               rdata[0] = ret;
      PQ_OP_PEEK, PQ_OP_SWAP:  rdata[1:0] = cur;
      default:                 rdata = '0;
    endcase
  end

endmodule

// File: rtl/pq_state_bank.sv
module pq_state_bank #(
  parameter int         NUM_SRC  = 16,
  parameter logic [1:0] RESET_PQ = 2'b01,
  parameter int         SRC_W    = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wr_src,
  input  logic [1:0]       wr_val,
  output logic [1:0]       state [NUM_SRC]
);

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          state[i] <= RESET_PQ;
        end else if (wr_en && (wr_src == SRC_W'(i))) begin
          state[i] <= wr_val;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pq_source_ctl.sv
module pq_source_ctl
  import pq_pkg::*;
#(
  parameter int               NUM_SRC   = 16,
  parameter int               PAGE_BITS = 12,
  parameter int               TWO_PAGE  = 1,
  parameter int               DATA_W    = 64,
  parameter logic [1:0]       RESET_PQ  = 2'b01,
  parameter logic [NUM_SRC-1:0] LSI_MAP = '0,
  parameter int               SRC_W     = $clog2(NUM_SRC),
  parameter int               ADDR_W    = PAGE_BITS + TWO_PAGE + SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pq_disable,
  input  logic               store_eoi_en,
  input  logic [NUM_SRC-1:0] lvl_in,
  input  logic               bus_valid,
  input  logic               bus_load,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic               trig_valid,
  output logic               trig_ready,
  input  logic [SRC_W-1:0]   trig_src,
  output logic               notify_valid,
  output logic [SRC_W-1:0]   notify_src
);

  pq_op_e            dec_op;
  logic [SRC_W-1:0]  dec_src;
  logic [1:0]        dec_val;

  pq_op_e            sel_op;
  logic [SRC_W-1:0]  sel_src;
  logic [1:0]        sel_val;
  logic              trig_in_range;

  logic [1:0]        state [NUM_SRC];
  logic [1:0]        cur_pq;
  logic              cur_lsi;
  logic              cur_lvl;

  logic [1:0]        eng_nxt;
  logic              eng_wr;
  logic              eng_ntf;
  logic [DATA_W-1:0] eng_rdata;

  pq_decode #(
    .NUM_SRC  (NUM_SRC),
    .PAGE_BITS(PAGE_BITS),
    .TWO_PAGE (TWO_PAGE),
    .SRC_W    (SRC_W),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .valid       (bus_valid),
    .load        (bus_load),
    .addr        (bus_addr),
    .store_eoi_en(store_eoi_en),
    .op          (dec_op),
    .src         (dec_src),
    .set_val     (dec_val)
  );

  // Bus accesses win; the trigger port waits for an idle bus cycle
  assign trig_ready    = ~bus_valid;
  assign trig_in_range = ({1'b0, trig_src} < (SRC_W+1)'(NUM_SRC));

  always_comb begin
    sel_op  = PQ_OP_NONE;
    sel_src = trig_src;
    sel_val = '0;
    if (bus_valid) begin
      sel_op  = dec_op;
      sel_src = dec_src;
      sel_val = dec_val;
    end else if (trig_valid && trig_in_range) begin
      sel_op  = PQ_OP_TRIG;
    end
  end

  always_comb begin
    cur_pq  = '0;
    cur_lsi = 1'b0;
    cur_lvl = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_src == SRC_W'(i)) begin
        cur_pq  = state[i];
        cur_lsi = LSI_MAP[i];
        cur_lvl = lvl_in[i];
      end
    end
  end

  pq_engine #(
    .DATA_W(DATA_W)
  ) u_engine (
    .op     (sel_op),
    .cur    (cur_pq),
    .set_val(sel_val),
    .lsi    (cur_lsi),
    .level  (cur_lvl),
    .bypass (pq_disable),
    .nxt    (eng_nxt),
    .wr     (eng_wr),
    .ntf    (eng_ntf),
    .rdata  (eng_rdata)
  );

  pq_state_bank #(
    .NUM_SRC (NUM_SRC),
    .RESET_PQ(RESET_PQ),
    .SRC_W   (SRC_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (eng_wr),
    .wr_src(sel_src),
    .wr_val(eng_nxt),
    .state (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      notify_valid <= 1'b0;
      notify_src   <= '0;
    end else begin
      rsp_valid    <= bus_valid & bus_load;
      rsp_data     <= (bus_valid & bus_load) ? eng_rdata : '0;
      notify_valid <= eng_ntf;
      notify_src   <= eng_ntf ? sel_src : '0;
    end
  end

endmodule

// File: rtl/pq_source_ctl_chk.sv
module pq_source_ctl_chk #(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pq_disable,
  input logic             bus_valid,
  input logic             bus_load,
  input logic             trig_valid,
  input logic             trig_ready,
  input logic [SRC_W-1:0] trig_src,
  input logic             rsp_valid,
  input logic             notify_valid,
  input logic [SRC_W-1:0] notify_src
);

  // R12: a load gets its response on the next cycle
  assert_rsp_follows_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_load) |=> rsp_valid);

  // R12: no response without a load in the previous cycle
  assert_rsp_only_after_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_load) |=> !rsp_valid);

  // R12: no notify without an accepted access or trigger
  assert_no_spurious_notify_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid || (trig_valid && trig_ready)) |=> !notify_valid);

  // R9: in bypass, an accepted hardware trigger always notifies its source
  assert_bypass_notifies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pq_disable && trig_valid && trig_ready &&
     ({1'b0, trig_src} < (SRC_W+1)'(NUM_SRC)))
    |=> (notify_valid && notify_src == $past(trig_src)));

endmodule

bind pq_source_ctl pq_source_ctl_chk #(
  .NUM_SRC(NUM_SRC),
  .SRC_W  (SRC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pq_disable  (pq_disable),
  .bus_valid   (bus_valid),
  .bus_load    (bus_load),
  .trig_valid  (trig_valid),
  .trig_ready  (trig_ready),
  .trig_src    (trig_src),
  .rsp_valid   (rsp_valid),
  .notify_valid(notify_valid),
  .notify_src  (notify_src)
);

// File: tb/pq_source_ctl_test.sv
module pq_source_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N      = 16;
  localparam int SW     = 4;
  localparam int AW     = 17;
  localparam logic [N-1:0] LSI = 16'h8000;

  // model operation codes
  localparam int M_NONE = 0, M_TRIG = 1, M_EOI = 2, M_PEEK = 3,
                 M_SWAP = 4, M_FORCE = 5, M_BAD = 6;

  typedef struct {
    int          due;
    bit          rv;
    logic [63:0] rd;
    bit          nv;
    int          ns;
    int          req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pq_disable = 1'b0;
  logic          store_eoi_en = 1'b0;
  logic [N-1:0]  lvl_in = '0;
  logic          bus_valid = 1'b0;
  logic          bus_load = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic          trig_valid = 1'b0;
  logic          trig_ready;
  logic [SW-1:0] trig_src = '0;
  logic          notify_valid;
  logic [SW-1:0] notify_src;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t q[$];
  logic [1:0] m_pq [N];

  pq_source_ctl #(.NUM_SRC(N), .LSI_MAP(LSI)) uut (
    .clk(clk), .rst_n(rst_n), .pq_disable(pq_disable),
    .store_eoi_en(store_eoi_en), .lvl_in(lvl_in),
    .bus_valid(bus_valid), .bus_load(bus_load), .bus_addr(bus_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_src(trig_src),
    .notify_valid(notify_valid), .notify_src(notify_src)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [AW-1:0] mk_addr(int src, bit odd, int off);
    return AW'((src << 13) | (int'(odd) << 12) | off);
  endfunction

  // Reference model of the state transitions (R3, R4, R9, R10)
  task automatic model_op(input int op, input int s, input int val,
                          output bit ret, output bit ntf);
    logic [1:0] c;
    c = m_pq[s];
    ret = 0; ntf = 0;
    case (op)
      M_TRIG: begin
        if (pq_disable) ntf = 1;
        else if (LSI[s]) begin
          if (c == 2'b00) begin m_pq[s] = 2'b10; ntf = 1; end
        end else if (c == 2'b00) begin m_pq[s] = 2'b10; ntf = 1; end
        else if (c[1]) m_pq[s] = 2'b11;
      end
      M_EOI: if (!pq_disable) begin
        if (LSI[s]) begin
          if (c == 2'b11) m_pq[s] = 2'b01;
          else if (c == 2'b10) begin
            if (lvl_in[s]) begin ntf = 1; ret = 1; end
            else m_pq[s] = 2'b00;
          end
        end else if (c == 2'b10) m_pq[s] = 2'b00;
        else if (c == 2'b11) begin m_pq[s] = 2'b10; ntf = 1; ret = 1; end
      end
      M_SWAP, M_FORCE: m_pq[s] = 2'(val);
      default: ;
    endcase
  endtask

  task automatic push_bus(input bit ld, input int s, input bit odd, input int off,
                          input int req, input int due);
    exp_t e;
    int op, val, blk;
    bit r, n;
    logic [1:0] old;
    val = (off >> 8) & 3;
    blk = (off >> 10) & 3;
    old = m_pq[s];
    if (ld) begin
      if (!odd) op = M_BAD;
      else if (blk < 2) op = M_EOI;
      else if (blk == 2) op = M_PEEK;
      else op = M_SWAP;
    end else begin
      if (!odd) op = M_TRIG;
      else if (blk == 1) op = store_eoi_en ? M_EOI : M_NONE;
      else if (blk == 3) op = M_FORCE;
      else op = M_NONE;
    end
    model_op(op, s, val, r, n);
    e.due = due; e.req = req; e.rv = ld; e.nv = n; e.ns = s;
    if (op == M_BAD) e.rd = '1;
    else if (op == M_EOI) e.rd = 64'(r);
    else e.rd = 64'(old);
    q.push_back(e);
  endtask

  task automatic bus_op(input bit ld, input int s, input bit odd, input int off,
                        input int req);
    push_bus(ld, s, odd, off, req, cyc + 1);
    bus_valid = 1'b1; bus_load = ld; bus_addr = mk_addr(s, odd, off);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic peek(input int s, input int req);
    bus_op(1'b1, s, 1'b1, 12'h800, req);
  endtask

  task automatic hw_trig(input int s, input int req);
    exp_t e;
    bit r, n;
    model_op(M_TRIG, s, 0, r, n);
    e.due = cyc + 1; e.req = req; e.rv = 0; e.rd = '0; e.nv = n; e.ns = s;
    q.push_back(e);
    trig_valid = 1'b1; trig_src = SW'(s);
    @(posedge clk); #1;
    trig_valid = 1'b0;
  endtask

  // Monitor: compare scheduled items on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rsp_valid !== e.rv || (e.rv && rsp_data !== e.rd)) begin
          failures++;
          $display("FAIL R%0d rsp: actual valid=%0b data=%h expected valid=%0b data=%h",
                   e.req, rsp_valid, rsp_data, e.rv, e.rd);
        end
        checks++;
        if (notify_valid !== e.nv || (e.nv && notify_src !== SW'(e.ns))) begin
          failures++;
          $display("FAIL R%0d notify: actual valid=%0b src=%0d expected valid=%0b src=%0d",
                   e.req, notify_valid, notify_src, e.nv, e.ns);
        end
      end else if (rsp_valid || notify_valid) begin
        checks++;
        failures++;
        $display("FAIL R12 unexpected output: actual rsp=%0b notify=%0b expected 0 0",
                 rsp_valid, notify_valid);
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_pq[i] = 2'b01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: outputs quiet after reset
    checks++;
    if (rsp_valid !== 1'b0 || notify_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual %0b%0b expected 00", rsp_valid, notify_valid);
    end
    // R1: every source holds the reset state (R2 source decode)
    for (int i = 0; i < N; i++) peek(i, 1);
    // R6: store force to 00
    bus_op(1'b0, 3, 1'b1, 12'hC00, 6);
    peek(3, 6);
    // R3: trigger-page stores
    bus_op(1'b0, 3, 1'b0, 12'h000, 3);
    bus_op(1'b0, 3, 1'b0, 12'h123, 3);
    peek(3, 3);
    // R4: end-of-interrupt loads
    bus_op(1'b1, 3, 1'b1, 12'h000, 4);
    bus_op(1'b1, 3, 1'b1, 12'h200, 4);
    bus_op(1'b1, 3, 1'b1, 12'h400, 4);
    peek(3, 4);
    // R3: masked source does not notify
    bus_op(1'b0, 5, 1'b0, 12'h000, 3);
    // R5: swapping loads
    bus_op(1'b1, 5, 1'b1, 12'hE00, 5);
    bus_op(1'b1, 5, 1'b1, 12'hD40, 5);
    bus_op(1'b1, 5, 1'b1, 12'hF00, 5);
    bus_op(1'b1, 5, 1'b1, 12'hC00, 5);
    bus_op(1'b1, 5, 1'b1, 12'hBFC, 5);
    // R6: ignored stores
    bus_op(1'b0, 5, 1'b1, 12'h800, 6);
    bus_op(1'b0, 5, 1'b1, 12'h000, 6);
    peek(5, 6);
    // R7: store EOI gated by enable
    bus_op(1'b0, 5, 1'b1, 12'hF00, 7);
    bus_op(1'b0, 5, 1'b1, 12'h400, 7);
    peek(5, 7);
    store_eoi_en = 1'b1;
    bus_op(1'b0, 5, 1'b1, 12'h400, 7);
    peek(5, 7);
    store_eoi_en = 1'b0;
    // R8: load from trigger page
    bus_op(1'b1, 5, 1'b0, 12'h800, 8);
    peek(5, 8);
    // R9: bypass
    pq_disable = 1'b1;
    bus_op(1'b0, 6, 1'b0, 12'h000, 9);
    hw_trig(6, 9);
    bus_op(1'b1, 6, 1'b1, 12'h000, 9);
    pq_disable = 1'b0;
    peek(6, 9);
    // R10: level-sensitive source 15
    bus_op(1'b0, 15, 1'b1, 12'hC00, 10);
    lvl_in[15] = 1'b1;
    hw_trig(15, 10);
    hw_trig(15, 10);
    peek(15, 10);
    bus_op(1'b1, 15, 1'b1, 12'h000, 10);
    lvl_in[15] = 1'b0;
    bus_op(1'b1, 15, 1'b1, 12'h000, 10);
    peek(15, 10);
    bus_op(1'b0, 15, 1'b1, 12'hF00, 10);
    bus_op(1'b1, 15, 1'b1, 12'h000, 10);
    peek(15, 10);
    // R11: trigger stalled behind a bus access, taken next cycle
    bus_op(1'b0, 7, 1'b1, 12'hC00, 11);
    begin
      exp_t e;
      bit r, n;
      trig_valid = 1'b1; trig_src = SW'(7);
      push_bus(1'b1, 7, 1'b1, 12'h800, 11, cyc + 1);
      bus_valid = 1'b1; bus_load = 1'b1; bus_addr = mk_addr(7, 1'b1, 12'h800);
      #1;
      checks++;
      if (trig_ready !== 1'b0) begin
        failures++;
        $display("FAIL R11 trig_ready during bus: actual %0b expected 0", trig_ready);
      end
      @(posedge clk); #1;
      bus_valid = 1'b0;
      #1;
      checks++;
      if (trig_ready !== 1'b1) begin
        failures++;
        $display("FAIL R11 trig_ready idle: actual %0b expected 1", trig_ready);
      end
      model_op(M_TRIG, 7, 0, r, n);
      e.due = cyc + 1; e.req = 11; e.rv = 0; e.rd = '0; e.nv = n; e.ns = 7;
      q.push_back(e);
      @(posedge clk); #1;
      trig_valid = 1'b0;
    end
    peek(7, 11);
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R12 pending items: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule